// File: doc/BRIEF.md
# Multi-Port GPIO Register Controller

This block holds the output, direction and mask state of several general-purpose I/O ports and exposes them to a simple register bus with an address, a write strobe with write data, and a read strobe with read data. Each port carries one output bit per pin. Software can change those bits in several ways: a whole-port write, a write that spares the pins whose mask bit is set, a write-ones-to-clear alias, a write-ones-to-invert alias, and single-pin aliases. Software can also read the synchronized pin levels as a whole port, as a masked port, or one pin at a time.

The pin side takes a synchronized input bus and two per-pin qualifiers. One says whether the pin is handed to GPIO. The other says whether the pin is used in analog mode, and analog pins always read as 0. The block drives a registered output value and a registered output enable for every pin. An enable is asserted only for a pin that is handed to GPIO and whose direction bit selects output. Reads return data one clock after the read strobe.

Top module: `gpio_ctrl`

## Requirements
- R1: After a synchronous reset, the output, direction and mask bits of every port are 0, `pin_oe` is all 0 and `rd_data` is 0.
- R2: The word address is `{kind[1:0], port, index[IDX_W-1:0]}`. Kind 0 is the byte-pin view, kind 1 is the word-pin view and kind 2 is the port register group. For kind 2, index 0 is OUT, 1 is DIR, 2 is MASK, 3 is PORT, 4 is MPORT, 5 is CLR and 6 is TGL. A read with `rd_en` high at a clock edge loads `rd_data` at that edge, and OUT, DIR and MASK read back their stored values.
- R3: A write to OUT or to PORT loads all output bits of the port from `wr_data`, with bit n driving pin n.
- R4: A write to MPORT changes only the output bits whose mask bit is 0. Bits whose mask bit is 1 keep their value.
- R5: A write to CLR clears every output bit whose data bit is 1 and leaves the others unchanged, whatever the mask holds.
- R6: A write to TGL inverts every output bit whose data bit is 1 and leaves the others unchanged, whatever the mask holds.
- R7: Reads of CLR and TGL return 0.
- R8: A PORT read returns the pin levels with every analog pin forced to 0. The GPIO-select qualifier does not affect it.
- R9: An MPORT read returns the PORT read value with every pin whose mask bit is 1 forced to 0.
- R10: A byte-pin read returns the pin's level in bit 0 and zeros above it. A byte-pin write sets the pin's output bit to data bit 0.
- R11: A word-pin read returns the pin's level copied into every bit. A word-pin write sets the pin's output bit to 1 when any data bit is 1, and to 0 otherwise.
- R12: `pin_oe` for a pin equals its direction bit ANDed with its GPIO-select bit, as they were at the previous clock edge.
- R13: Writes to kind 3 or to kind-2 indexes 7 and above change no state. Reads of them return 0.
- R14: Output bits change only at a clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address {kind, port, index} |
| wr_en | input | 1 | Write strobe |
| wr_data | input | PORT_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | PORT_W | Read data, valid the cycle after rd_en |
| pin_in | input | NUM_PORTS*PORT_W | Synchronized pin levels, port-major |
| gpio_sel | input | NUM_PORTS*PORT_W | Pin handed to GPIO |
| analog | input | NUM_PORTS*PORT_W | Pin in analog mode |
| pin_out | output | NUM_PORTS*PORT_W | Output bit per pin |
| pin_oe | output | NUM_PORTS*PORT_W | Output enable per pin |

## Verification
On every cycle, the assertions check four kinds of behaviour. They check the output-enable qualification and the one-cycle delay of the enables. They check the effect of clear, invert and masked-port writes on the output bits. They check that output bits stay put without a write. They also check the shape of the read data for the alias views: zeros above bit 0 for byte-pin reads, a uniform word for word-pin reads, and zero for reads of CLR and TGL. Only the bench scenarios show the exact values. Those include the analog forcing and mask forcing on port reads, the single-pin write rules, the register read-back, and the fact that reserved addresses leave every port untouched.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  typedef enum logic [1:0] {
    K_BYTEPIN = 2'd0,
    K_WORDPIN = 2'd1,
    K_PORTREG = 2'd2,
    K_NONE    = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    RS_OUT   = 3'd0,
    RS_DIR   = 3'd1,
    RS_MASK  = 3'd2,
    RS_PORT  = 3'd3,
    RS_MPORT = 3'd4,
    RS_CLR   = 3'd5,
    RS_TGL   = 3'd6,
    RS_RSVD  = 3'd7
  } regsel_e;

  typedef struct packed {
    logic set_all;
    logic set_masked;
    logic clr;
    logic tgl;
    logic dir;
    logic mask;
    logic pin;
  } wcmd_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int IDX_W     = 5,
  parameter int PB        = 2,
  parameter int ADDR_W    = 2 + PB + IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  output kind_e             kind,
  output logic [PB-1:0]     port,
  output logic [IDX_W-1:0]  idx,
  output logic              port_ok,
  output wcmd_t             cmd,
  output logic              pin_val
);

  regsel_e sel;
  logic    is_reg;

  assign kind    = kind_e'(addr[ADDR_W-1 -: 2]);
  assign port    = addr[IDX_W +: PB];
  assign idx     = addr[IDX_W-1:0];
  assign port_ok = (int'(port) < NUM_PORTS);
  assign sel     = regsel_e'(idx[2:0]);
  assign is_reg  = (kind == K_PORTREG) && (idx[IDX_W-1:3] == '0);
  assign pin_val = (kind == K_BYTEPIN) ? wr_data[0] : (|wr_data);

  always_comb begin
    cmd = '0;
    if (wr_en && port_ok) begin
      cmd.pin = (kind == K_BYTEPIN) || (kind == K_WORDPIN);
      if (is_reg) begin
        cmd.set_all    = (sel == RS_OUT) || (sel == RS_PORT);
        cmd.set_masked = (sel == RS_MPORT);
        cmd.clr        = (sel == RS_CLR);
        cmd.tgl        = (sel == RS_TGL);
        cmd.dir        = (sel == RS_DIR);
        cmd.mask       = (sel == RS_MASK);
      end
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_ctrl_pkg::*;
#(
  parameter int PORT_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  wcmd_t             cmd,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  pin_idx,
  input  logic              pin_val,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] mask_q
);

  logic [PORT_W-1:0] out_nx;

  // Clear is applied before invert when both are requested together.
  always_comb begin
    out_nx = out_q;
    if (cmd.set_all)    out_nx = wr_data;
    if (cmd.set_masked) out_nx = (out_q & mask_q) | (wr_data & ~mask_q);
    if (cmd.clr)        out_nx = out_nx & ~wr_data;
    if (cmd.tgl)        out_nx = out_nx ^ wr_data;
    if (cmd.pin)        out_nx[pin_idx] = pin_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      out_q <= out_nx;
      if (cmd.dir)  dir_q  <= wr_data;
      if (cmd.mask) mask_q <= wr_data;
    end
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int IDX_W     = 5,
  parameter int PB        = 2
) (
  input  kind_e                     kind,
  input  logic [PB-1:0]             port,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      port_ok,
  input  logic [NUM_PORTS*PORT_W-1:0] out_all,
  input  logic [NUM_PORTS*PORT_W-1:0] dir_all,
  input  logic [NUM_PORTS*PORT_W-1:0] mask_all,
  input  logic [NUM_PORTS*PORT_W-1:0] state_all,
  output logic [PORT_W-1:0]         rdata
);

  logic [PORT_W-1:0] o_v, d_v, m_v, s_v;

  assign o_v = out_all[int'(port)*PORT_W +: PORT_W];
  assign d_v = dir_all[int'(port)*PORT_W +: PORT_W];
  assign m_v = mask_all[int'(port)*PORT_W +: PORT_W];
  assign s_v = state_all[int'(port)*PORT_W +: PORT_W];

  always_comb begin
    rdata = '0;
    if (port_ok) begin
      unique case (kind)
        K_BYTEPIN: rdata = {{(PORT_W-1){1'b0}}, s_v[idx]};
        K_WORDPIN: rdata = {PORT_W{s_v[idx]}};
        K_PORTREG: begin
          if (idx[IDX_W-1:3] == '0) begin
            unique case (regsel_e'(idx[2:0]))
              RS_OUT:   rdata = o_v;
              RS_DIR:   rdata = d_v;
              RS_MASK:  rdata = m_v;
              RS_PORT:  rdata = s_v;
              RS_MPORT: rdata = s_v & ~m_v;
              default:  rdata = '0;
            endcase
          end
        end
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int PORT_W    = 32,
  localparam int IDX_W     = $clog2(PORT_W),
  localparam int PB        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W    = 2 + PB + IDX_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [PORT_W-1:0]           wr_data,
  input  logic                        rd_en,
  output logic [PORT_W-1:0]           rd_data,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  input  logic [NUM_PORTS*PORT_W-1:0] gpio_sel,
  input  logic [NUM_PORTS*PORT_W-1:0] analog,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe
);

  localparam int TOT_W = NUM_PORTS * PORT_W;

  kind_e             kind;
  logic [PB-1:0]     port;
  logic [IDX_W-1:0]  idx;
  logic              port_ok;
  wcmd_t             cmd;
  logic              pin_val;
  logic [TOT_W-1:0]  out_all, dir_all, mask_all, state_all;
  logic [PORT_W-1:0] rdata_c;

  gpio_addr_dec #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .IDX_W(IDX_W), .PB(PB), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .kind(kind), .port(port),
    .idx(idx), .port_ok(port_ok), .cmd(cmd), .pin_val(pin_val)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    wcmd_t cmd_p;
    assign cmd_p = (port == PB'(p)) ? cmd : '0;

    gpio_port #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_port (
      .clk(clk), .rst(rst), .cmd(cmd_p), .wr_data(wr_data), .pin_idx(idx),
      .pin_val(pin_val),
      .out_q(out_all[p*PORT_W +: PORT_W]),
      .dir_q(dir_all[p*PORT_W +: PORT_W]),
      .mask_q(mask_all[p*PORT_W +: PORT_W])
    );
  end

  assign state_all = pin_in & ~analog;

  gpio_rd_mux #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .IDX_W(IDX_W), .PB(PB)
  ) u_rd (
    .kind(kind), .port(port), .idx(idx), .port_ok(port_ok), .out_all(out_all),
    .dir_all(dir_all), .mask_all(mask_all), .state_all(state_all), .rdata(rdata_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      pin_oe  <= '0;
    end else begin
      if (rd_en) rd_data <= rdata_c;
      pin_oe <= dir_all & gpio_sel;
    end
  end

  assign pin_out = out_all;

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter  int NUM_PORTS = 4,
  parameter  int PORT_W    = 32,
  localparam int IDX_W     = $clog2(PORT_W),
  localparam int PB        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W    = 2 + PB + IDX_W
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           addr,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [PORT_W-1:0]           wr_data,
  input logic [PORT_W-1:0]           rd_data,
  input logic [NUM_PORTS*PORT_W-1:0] pin_out,
  input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  input logic [NUM_PORTS*PORT_W-1:0] gpio_sel,
  input logic [NUM_PORTS*PORT_W-1:0] dir_all,
  input logic [NUM_PORTS*PORT_W-1:0] mask_all
);

  logic [1:0]       c_kind;
  logic [PB-1:0]    c_port;
  logic [IDX_W-1:0] c_idx;
  logic             c_reg;

  assign c_kind = addr[ADDR_W-1 -: 2];
  assign c_port = addr[IDX_W +: PB];
  assign c_idx  = addr[IDX_W-1:0];
  assign c_reg  = (c_kind == 2'd2) && (c_idx[IDX_W-1:3] == '0);

  AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    pin_oe == $past(dir_all & gpio_sel)); // R12

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pin_out)); // R14

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && c_reg && (c_idx[2:0] == 3'd5 || c_idx[2:0] == 3'd6)) |=> rd_data == '0); // R7

  AST_BYTEPIN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && c_kind == 2'd0) |=> rd_data[PORT_W-1:1] == '0); // R10

  AST_WORDPIN_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (rd_en && c_kind == 2'd1) |=> (rd_data == '0 || rd_data == '1)); // R11

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    logic hit;
    assign hit = wr_en && c_reg && (c_port == PB'(p));

    AST_CLR_ONES: assert property (@(posedge clk) disable iff (rst)
      (hit && c_idx[2:0] == 3'd5) |=>
        (pin_out[p*PORT_W +: PORT_W] & $past(wr_data)) == '0 &&
        (pin_out[p*PORT_W +: PORT_W] & ~$past(wr_data)) ==
        ($past(pin_out[p*PORT_W +: PORT_W]) & ~$past(wr_data))); // R5

    AST_TGL_ONES: assert property (@(posedge clk) disable iff (rst)
      (hit && c_idx[2:0] == 3'd6) |=>
        pin_out[p*PORT_W +: PORT_W] ==
        ($past(pin_out[p*PORT_W +: PORT_W]) ^ $past(wr_data))); // R6

    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
      (hit && c_idx[2:0] == 3'd4) |=>
        ((pin_out[p*PORT_W +: PORT_W] ^ $past(pin_out[p*PORT_W +: PORT_W])) &
         $past(mask_all[p*PORT_W +: PORT_W])) == '0); // R4
  end

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (.*);

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;

  localparam int NP     = 4;
  localparam int W      = 32;
  localparam int IDX_W  = $clog2(W);
  localparam int PB     = (NP > 1) ? $clog2(NP) : 1;
  localparam int ADDR_W = 2 + PB + IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [W-1:0]      wr_data = '0;
  logic              rd_en = 1'b0;
  logic [W-1:0]      rd_data;
  logic [NP*W-1:0]   pin_in = '0, gpio_sel = '0, analog = '0;
  logic [NP*W-1:0]   pin_out, pin_oe;

  int tests = 0;
  int fails = 0;

  logic [W-1:0] e_out [NP];
  logic [W-1:0] e_dir [NP];
  logic [W-1:0] e_mask[NP];

  always #4 clk = ~clk;

  gpio_ctrl #(.NUM_PORTS(NP), .PORT_W(W)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .gpio_sel(gpio_sel),
    .analog(analog), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [ADDR_W-1:0] mk(input int kind, input int port, input int idx);
    return {kind[1:0], port[PB-1:0], idx[IDX_W-1:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] got,
                     input logic [W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic chk_out(input string req, input int p);
    chk(req, $sformatf("pin_out port %0d", p), pin_out[p*W +: W], e_out[p]);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R1", "pin_out", pin_out[W-1:0] | pin_out[NP*W-1 -: W], '0);
    chk("R1", "pin_oe", pin_oe[W-1:0], '0);
    chk("R1", "rd_data", rd_data, '0);
    rd(mk(2, 0, 0), v); chk("R1", "OUT p0", v, '0);
    rd(mk(2, 3, 1), v); chk("R1", "DIR p3", v, '0);
    rd(mk(2, 2, 2), v); chk("R1", "MASK p2", v, '0);
  endtask

  task automatic t_port_write();
    logic [W-1:0] v;
    wr(mk(2, 1, 3), 32'hA5A5_1234); e_out[1] = 32'hA5A5_1234;
    chk_out("R3", 1);
    rd(mk(2, 1, 0), v); chk("R2", "OUT readback p1", v, e_out[1]);
    wr(mk(2, 2, 0), 32'hDEAD_BEEF); e_out[2] = 32'hDEAD_BEEF;
    chk_out("R3", 2);
    chk_out("R3", 1);
    repeat (3) @(negedge clk);
    chk_out("R14", 2);
  endtask

  task automatic t_masked_write();
    logic [W-1:0] v;
    wr(mk(2, 1, 2), 32'hFFFF_0000); e_mask[1] = 32'hFFFF_0000;
    rd(mk(2, 1, 2), v); chk("R2", "MASK readback p1", v, e_mask[1]);
    wr(mk(2, 1, 4), 32'h0F0F_FFFF);
    e_out[1] = (e_out[1] & e_mask[1]) | (32'h0F0F_FFFF & ~e_mask[1]);
    chk_out("R4", 1);
  endtask

  task automatic t_clr_tgl();
    logic [W-1:0] v;
    wr(mk(2, 1, 5), 32'hF000_000F); e_out[1] = e_out[1] & ~32'hF000_000F;
    chk_out("R5", 1);
    rd(mk(2, 1, 5), v); chk("R7", "CLR read", v, '0);
    wr(mk(2, 1, 6), 32'h0FF0_00F0); e_out[1] = e_out[1] ^ 32'h0FF0_00F0;
    chk_out("R6", 1);
    rd(mk(2, 1, 6), v); chk("R7", "TGL read", v, '0);
  endtask

  task automatic t_pins();
    logic [W-1:0] v, st;
    pin_in[W-1:0] = 32'h1234_00F8;
    analog[W-1:0] = 32'h0000_0010;
    gpio_sel = '0;
    st = 32'h1234_00F8 & ~32'h0000_0010;
    rd(mk(2, 0, 3), v); chk("R8", "PORT read p0", v, st);
    wr(mk(2, 0, 2), 32'h00FF_00FF); e_mask[0] = 32'h00FF_00FF;
    rd(mk(2, 0, 4), v); chk("R9", "MPORT read p0", v, st & ~e_mask[0]);
  endtask

  task automatic t_byte_pin();
    logic [W-1:0] v;
    rd(mk(0, 0, 3), v); chk("R10", "byte-pin read pin3", v, 32'h1);
    rd(mk(0, 0, 4), v); chk("R10", "byte-pin read analog pin4", v, 32'h0);
    wr(mk(0, 3, 7), 32'h0000_0001); e_out[3][7] = 1'b1;
    chk_out("R10", 3);
    wr(mk(0, 3, 7), 32'hFFFF_FFFE); e_out[3][7] = 1'b0;
    chk_out("R10", 3);
  endtask

  task automatic t_word_pin();
    logic [W-1:0] v;
    rd(mk(1, 0, 3), v); chk("R11", "word-pin read pin3", v, '1);
    rd(mk(1, 0, 4), v); chk("R11", "word-pin read analog pin4", v, '0);
    wr(mk(1, 3, 9), 32'h0000_0100); e_out[3][9] = 1'b1;
    chk_out("R11", 3);
    wr(mk(1, 3, 9), 32'h0000_0000); e_out[3][9] = 1'b0;
    chk_out("R11", 3);
  endtask

  task automatic t_oe();
    logic [W-1:0] v;
    gpio_sel[W-1:0] = 32'h00FF_00FF;
    wr(mk(2, 0, 1), 32'hFFFF_0F00); e_dir[0] = 32'hFFFF_0F00;
    rd(mk(2, 0, 1), v); chk("R2", "DIR readback p0", v, e_dir[0]);
    chk("R12", "pin_oe p0", pin_oe[W-1:0], e_dir[0] & 32'h00FF_00FF);
    @(negedge clk);
    gpio_sel[W-1:0] = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R12", "pin_oe p0 after select", pin_oe[W-1:0], e_dir[0]);
    chk("R12", "pin_oe p1", pin_oe[2*W-1 -: W], '0);
  endtask

  task automatic t_unused();
    logic [W-1:0] v;
    wr(mk(2, 2, 9), 32'hFFFF_FFFF);
    chk_out("R13", 2);
    wr(mk(3, 2, 0), 32'h0000_0000);
    chk_out("R13", 2);
    wr(mk(2, 2, 7), 32'h0000_0000);
    chk_out("R13", 2);
    rd(mk(2, 2, 9), v); chk("R13", "reserved read", v, '0);
    rd(mk(3, 0, 3), v); chk("R13", "kind3 read", v, '0);
    rd(mk(2, 2, 2), v); chk("R13", "MASK p2 untouched", v, e_mask[2]);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      e_out[p] = '0; e_dir[p] = '0; e_mask[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_port_write();
    t_masked_write();
    t_clr_tgl();
    t_pins();
    t_byte_pin();
    t_word_pin();
    t_oe();
    t_unused();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R14 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule